// File: doc/BRIEF.md
# Supply-Rail Programming Command Decoder

This block turns a programming protocol that rides on the supply rail into commands. Three single-cycle event inputs stand in for the rail level detectors: a large opening pulse, a large closing pulse and a store pulse. A fourth input marks each small modulation pulse. The block counts ticks of the 32768 Hz time base between successive modulation pulses. It sorts each measured interval into one of three commands: advance the instruction state, shift a 0 into the data register, or shift a 1 into it.

The instruction state runs from 1 to 6. State 1 passes the divided oscillator probe to the load-resistor enable, and state 2 passes the inhibition-time probe. States 3, 4 and 5 select writable words 0, 1 and 2. State 6 selects a fixed, read-only type word. The 8-bit register has two uses. It holds the data for a store. In check mode a single walking 1 in the register points at the bit that drives the load-resistor enable. A store merges the register into the selected word with a bitwise OR, because a programmed cell can never return to 0.

Top module: `supmod_prog_decoder`

## Requirements
- R1: An opening pulse sets the instruction state to 1 and clears the data register, whatever the state was before.
- R2: The first modulation pulse after an opening pulse only sets the time reference. It changes neither the state nor the register.
- R3: A measured interval of 20 to 26 ticks raises the instruction state by one. The state stops at 6 and never exceeds it.
- R4: An interval of 53 to 58 ticks shifts in a 0, and an interval of 86 to 91 ticks shifts in a 1. The new bit enters at bit 7 and every older bit moves one place toward bit 0, so after eight shifts the first bit entered sits in bit 0. The register changes only on an opening pulse or a modulation pulse.
- R5: An interval that falls in none of the three windows is ignored. The time reference is kept, so the next interval is measured from the last accepted pulse.
- R6: A closing pulse, a store pulse, or 65536 ticks with no modulation pulse returns the state to 0. The priority is opening, then closing, then store, then modulation.
- R7: A store pulse in states 3 to 5 produces a one-cycle write request in the next cycle. It carries the word index (state minus 3) and the data (old word OR register), and the word keeps the merged value. A store in any other state writes nothing.
- R8: In states 3 to 6 the load-resistor enable is 1 when the selected word has a 1 at any position where the register has a 1. In state 6 that word is the fixed type code 0x21.
- R9: In state 1 the load-resistor enable follows the oscillator probe, and in state 2 it follows the inhibition probe. In state 0 it is 0.
- R10: Modulation pulses arriving while the state is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe of the 32768 Hz time base |
| start_evt | input | 1 | Large opening pulse detected |
| stop_evt | input | 1 | Large closing pulse detected |
| store_evt | input | 1 | Store-level pulse detected |
| mod_evt | input | 1 | Small modulation pulse detected |
| osc_div_in | input | 1 | Divided oscillator probe signal |
| inhib_in | input | 1 | Inhibition-time probe signal |
| inst_state | output | 3 | Current instruction state, 0 when idle |
| shift_reg | output | 8 | Data register and read pointer |
| wr_req | output | 1 | One-cycle write request |
| wr_sel | output | 2 | Index of the written word |
| wr_data | output | 8 | Merged value written to the word |
| load_en | output | 1 | Load-resistor enable |

## Verification
The assertions assume that each detector event is a clean single-cycle strobe and that the tick never runs faster than the clock. They also assume that an opening pulse outranks any event in the same cycle. The bench raises each event for exactly one cycle at a falling edge and never raises two events together. It holds tick high every cycle, so one interval tick equals one clock and every window edge can be hit exactly.

// File: rtl/supmod_pkg.sv
package supmod_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ADV  = 2'd1,
        CMD_ZERO = 2'd2,
        CMD_ONE  = 2'd3
    } supmod_cmd_e;

    localparam logic [STATE_W-1:0] ST_IDLE   = 3'd0;
    localparam logic [STATE_W-1:0] ST_OSC    = 3'd1;
    localparam logic [STATE_W-1:0] ST_INHIB  = 3'd2;
    localparam logic [STATE_W-1:0] ST_WORD_A = 3'd3;
    localparam logic [STATE_W-1:0] ST_WORD_C = 3'd5;
    localparam logic [STATE_W-1:0] ST_WORD_D = 3'd6;

endpackage

// File: rtl/supmod_interval_timer.sv
module supmod_interval_timer
    import supmod_pkg::*;
#(
    parameter int T1_MIN = 20,
    parameter int T1_MAX = 26,
    parameter int T2_MIN = 53,
    parameter int T2_MAX = 58,
    parameter int T3_MIN = 86,
    parameter int T3_MAX = 91
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        enable,
    input  logic        tick,
    input  logic        mod_evt,
    output supmod_cmd_e cmd_o
);

    localparam int CW = $clog2(T3_MAX + 2);
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          tmr_q, tmr_d;
    logic [CW-1:0] meas;

    function automatic supmod_cmd_e classify(input int m);
        if (m >= T1_MIN && m <= T1_MAX) return CMD_ADV;
        if (m >= T2_MIN && m <= T2_MAX) return CMD_ZERO;
        if (m >= T3_MIN && m <= T3_MAX) return CMD_ONE;
        return CMD_NONE;
    endfunction

    always_comb begin
        tmr_d = tmr_q;
        cmd_o = CMD_NONE;
        meas  = (tick && tmr_q.cnt != CNT_MAX) ? tmr_q.cnt + 1'b1 : tmr_q.cnt;
        if (restart || !enable) begin
            tmr_d = '0;
        end else if (mod_evt) begin
            if (!tmr_q.armed) begin
                tmr_d.armed = 1'b1;
                tmr_d.cnt   = '0;
            end else begin
                cmd_o     = classify(int'(meas));
                tmr_d.cnt = (cmd_o != CMD_NONE) ? '0 : meas;
            end
        end else if (tmr_q.armed) begin
            tmr_d.cnt = meas;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/supmod_word_bank.sv
module supmod_word_bank #(
    parameter int               DATA_W    = 8,
    parameter int               NUM_WR    = 3,
    parameter logic [DATA_W-1:0] TYPE_CODE = 8'h21
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(NUM_WR+1)-1:0]    wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [$clog2(NUM_WR+1)-1:0]    rd_sel,
    output logic [DATA_W-1:0]              rd_word
);

    localparam int SEL_W = $clog2(NUM_WR + 1);

    logic [DATA_W-1:0] word_q [NUM_WR];

    for (genvar g = 0; g < NUM_WR; g++) begin : g_word
        logic [DATA_W-1:0] word_d;
        always_comb begin
            word_d = word_q[g];
            if (wr_en && wr_sel == SEL_W'(g)) word_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[g] <= '0;
            else        word_q[g] <= word_d;
        end
    end

    always_comb begin
        rd_word = TYPE_CODE;
        for (int i = 0; i < NUM_WR; i++) begin
            if (rd_sel == SEL_W'(i)) rd_word = word_q[i];
        end
    end

endmodule

// File: rtl/supmod_prog_decoder.sv
module supmod_prog_decoder
    import supmod_pkg::*;
#(
    parameter int               DATA_W        = 8,
    parameter int               TIMEOUT_TICKS = 65536,
    parameter logic [DATA_W-1:0] TYPE_CODE     = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              store_evt,
    input  logic              mod_evt,
    input  logic              osc_div_in,
    input  logic              inhib_in,
    output logic [2:0]        inst_state,
    output logic [DATA_W-1:0] shift_reg,
    output logic              wr_req,
    output logic [1:0]        wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              load_en
);

    localparam int NUM_WR = int'(ST_WORD_C - ST_WORD_A) + 1;
    localparam int SEL_W  = $clog2(NUM_WR + 1);
    localparam int IW     = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [IW-1:0] IDLE_MAX = '1;

    typedef struct packed {
        logic [STATE_W-1:0] inst;
        logic [DATA_W-1:0]  sr;
        logic [IW-1:0]      idle;
        logic               wr_req;
        logic [SEL_W-1:0]   wr_sel;
        logic [DATA_W-1:0]  wr_data;
    } dec_t;

    dec_t               dec_q, dec_d;
    supmod_cmd_e        cmd;
    logic               store_ok;
    logic [SEL_W-1:0]   word_sel;
    logic [STATE_W-1:0] word_off;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  merged;
    logic [IW-1:0]      idle_next;
    logic               active;

    assign active   = (dec_q.inst != ST_IDLE);
    assign word_off = dec_q.inst - ST_WORD_A;
    assign word_sel = (dec_q.inst >= ST_WORD_A) ? word_off[SEL_W-1:0] : '0;
    assign merged   = rd_word | dec_q.sr;

    supmod_interval_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_evt),
        .enable  (active),
        .tick    (tick),
        .mod_evt (mod_evt),
        .cmd_o   (cmd)
    );

    supmod_word_bank #(
        .DATA_W    (DATA_W),
        .NUM_WR    (NUM_WR),
        .TYPE_CODE (TYPE_CODE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_ok),
        .wr_sel  (word_sel),
        .wr_data (merged),
        .rd_sel  (word_sel),
        .rd_word (rd_word)
    );

    always_comb begin
        dec_d        = dec_q;
        dec_d.wr_req = 1'b0;
        store_ok     = 1'b0;
        idle_next    = (tick && dec_q.idle != IDLE_MAX) ? dec_q.idle + 1'b1 : dec_q.idle;
        if (start_evt) begin
            dec_d.inst = ST_OSC;
            dec_d.sr   = '0;
            dec_d.idle = '0;
        end else if (stop_evt) begin
            dec_d.inst = ST_IDLE;
            dec_d.idle = '0;
        end else if (store_evt) begin
            dec_d.inst = ST_IDLE;
            dec_d.idle = '0;
            if (dec_q.inst >= ST_WORD_A && dec_q.inst <= ST_WORD_C) begin
                store_ok      = 1'b1;
                dec_d.wr_req  = 1'b1;
                dec_d.wr_sel  = word_sel;
                dec_d.wr_data = merged;
            end
        end else if (active) begin
            unique case (cmd)
                CMD_ADV:  if (dec_q.inst < ST_WORD_D) dec_d.inst = dec_q.inst + 3'd1;
                CMD_ZERO: dec_d.sr = {1'b0, dec_q.sr[DATA_W-1:1]};
                CMD_ONE:  dec_d.sr = {1'b1, dec_q.sr[DATA_W-1:1]};
                default:  ;
            endcase
            if (mod_evt) begin
                dec_d.idle = '0;
            end else begin
                dec_d.idle = idle_next;
                if (int'(idle_next) >= TIMEOUT_TICKS) begin
                    dec_d.inst = ST_IDLE;
                    dec_d.idle = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    always_comb begin
        unique case (dec_q.inst)
            ST_OSC:   load_en = osc_div_in;
            ST_INHIB: load_en = inhib_in;
            ST_IDLE:  load_en = 1'b0;
            default:  load_en = (dec_q.inst <= ST_WORD_D) && |(rd_word & dec_q.sr);
        endcase
    end

    assign inst_state = dec_q.inst;
    assign shift_reg  = dec_q.sr;
    assign wr_req     = dec_q.wr_req;
    assign wr_sel     = dec_q.wr_sel;
    assign wr_data    = dec_q.wr_data;

endmodule

// File: rtl/supmod_prog_checker.sv
module supmod_prog_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       mod_evt,
    input logic [2:0] inst_state,
    input logic [7:0] shift_reg,
    input logic       wr_req,
    input logic [1:0] wr_sel,
    input logic       load_en
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (inst_state == 3'd1 && shift_reg == 8'h00)); // R1

    AST_STATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inst_state <= 3'd6); // R3

    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_evt && !mod_evt) |=> $stable(shift_reg)); // R4

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> inst_state == 3'd0); // R6

    AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (inst_state == 3'd0 && wr_sel <= 2'd2)); // R7

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        inst_state == 3'd0 |-> !load_en); // R9

endmodule

bind supmod_prog_decoder supmod_prog_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .mod_evt    (mod_evt),
    .inst_state (inst_state),
    .shift_reg  (shift_reg),
    .wr_req     (wr_req),
    .wr_sel     (wr_sel),
    .load_en    (load_en)
);

// File: tb/supmod_prog_decoder_test.sv
`timescale 1ns/1ps
module supmod_prog_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start_evt = 1'b0, stop_evt = 1'b0, store_evt = 1'b0, mod_evt = 1'b0;
    logic       osc_div_in = 1'b0, inhib_in = 1'b0;
    logic [2:0] inst_state;
    logic [7:0] shift_reg;
    logic       wr_req;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       load_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    supmod_prog_decoder uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_evt(start_evt), .stop_evt(stop_evt), .store_evt(store_evt), .mod_evt(mod_evt),
        .osc_div_in(osc_div_in), .inhib_in(inhib_in),
        .inst_state(inst_state), .shift_reg(shift_reg),
        .wr_req(wr_req), .wr_sel(wr_sel), .wr_data(wr_data), .load_en(load_en)
    );

    // gap in ticks from the previous pulse, expected state and register after it
    localparam int NV = 15;
    localparam int VGAP [NV] = '{23, 20, 88, 55, 91, 53, 40, 48, 26, 27, 59, 19, 4, 92, 2};
    localparam int VST  [NV] = '{ 2,  3,  3,  3,  3,  3,  3,  3,  4,  4,  4,  4, 5,  5, 5};
    localparam int VSR  [NV] = '{'h00, 'h00, 'h80, 'h40, 'hA0, 'h50, 'h50, 'hA8,
                                 'hA8, 'hA8, 'hD4, 'hD4, 'hD4, 'hD4, 'hD4};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(); start_evt = 1'b1; @(negedge clk); start_evt = 1'b0; endtask
    task automatic pulse_stop();  stop_evt  = 1'b1; @(negedge clk); stop_evt  = 1'b0; endtask
    task automatic pulse_store(); store_evt = 1'b1; @(negedge clk); store_evt = 1'b0; endtask

    task automatic mod_after(input int gap);
        repeat (gap - 1) @(negedge clk);
        mod_evt = 1'b1;
        @(negedge clk);
        mod_evt = 1'b0;
    endtask

    task automatic adv();                 mod_after(23);             endtask
    task automatic shift_bit(input bit b); mod_after(b ? 88 : 55);   endtask

    task automatic open_state(input int st);
        pulse_start();
        mod_after(3);
        for (int i = 1; i < st; i++) adv();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset R6 state", inst_state, 0);
        check("reset R4 reg", shift_reg, 0);
        check("reset R7 wr_req", wr_req, 0);
        check("reset R9 load_en", load_en, 0);

        // R10: pulses while idle do nothing
        mod_after(3); mod_after(23); mod_after(88);
        check("R10 idle state", inst_state, 0);
        check("R10 idle reg", shift_reg, 0);

        // R1, R2
        pulse_start();
        check("R1 state", inst_state, 1);
        check("R1 reg", shift_reg, 0);
        mod_after(23);
        check("R2 reference state", inst_state, 1);
        check("R2 reference reg", shift_reg, 0);

        // vector table: R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            mod_after(VGAP[v]);
            check($sformatf("R3/R4/R5 vec%0d state", v), inst_state, VST[v]);
            check($sformatf("R3/R4/R5 vec%0d reg", v), shift_reg, VSR[v]);
        end

        // R7: store in state 5 writes word 2
        pulse_store();
        check("R7 wr_req", wr_req, 1);
        check("R7 wr_sel", wr_sel, 2);
        check("R7 wr_data", wr_data, 'hD4);
        check("R6 store clears", inst_state, 0);
        @(negedge clk);
        check("R7 single pulse", wr_req, 0);

        // R1 again: opening pulse mid-session clears register
        open_state(4);
        for (int i = 0; i < 8; i++) shift_bit(i < 2);
        check("R4 lsb first", shift_reg, 'h03);
        pulse_start();
        check("R1 mid clear", shift_reg, 0);
        mod_after(3); adv(); adv(); adv();
        for (int i = 0; i < 8; i++) shift_bit(i < 2);
        pulse_store();
        check("R7 word1 sel", wr_sel, 1);
        check("R7 word1 data", wr_data, 'h03);
        open_state(4);
        shift_bit(1);
        pulse_store();
        check("R7 OR merge", wr_data, 'h83);

        // R8: walk through word 1 = 0x83
        open_state(4);
        shift_bit(1);
        #1 check("R8 bit7", load_en, 1);
        shift_bit(0);
        #1 check("R8 bit6", load_en, 0);
        for (int i = 0; i < 6; i++) shift_bit(0);
        #1 check("R8 bit0", load_en, 1);
        check("R8 pointer", shift_reg, 'h01);

        // R3 saturation, R8 type word, R7 store rejected in state 6
        open_state(6);
        check("R3 state6", inst_state, 6);
        adv();
        check("R3 saturate", inst_state, 6);
        shift_bit(1);
        #1 check("R8 type bit7", load_en, 0);
        shift_bit(0); shift_bit(0);
        #1 check("R8 type bit5", load_en, 1);
        pulse_store();
        check("R7 no write state6", wr_req, 0);
        check("R6 store clears6", inst_state, 0);

        // R9 probes
        pulse_start();
        osc_div_in = 1'b1; #1 check("R9 osc high", load_en, 1);
        osc_div_in = 1'b0; #1 check("R9 osc low", load_en, 0);
        @(negedge clk);
        mod_after(3); adv();
        inhib_in = 1'b1; #1 check("R9 inhib high", load_en, 1);
        osc_div_in = 1'b1; inhib_in = 1'b0; #1 check("R9 inhib low", load_en, 0);
        osc_div_in = 1'b0;
        @(negedge clk);
        pulse_store();
        check("R7 no write state2", wr_req, 0);

        // R6 stop
        open_state(3);
        pulse_stop();
        check("R6 stop", inst_state, 0);

        // R6 timeout
        open_state(2);
        repeat (65000) @(negedge clk);
        check("R6 before timeout", inst_state, 2);
        repeat (600) @(negedge clk);
        check("R6 after timeout", inst_state, 0);

        summary();
        $finish;
    end

endmodule